// File: doc/BRIEF.md
# Complementary PWM Deadtime Inserter

This block turns one raw PWM reference into a pair of complementary gate signals. Channel A requests its active state while the reference is high, and channel B requests its active state while the reference is low. When a channel is asked to go active, its output is held at the inactive level for a programmable guard interval before it switches. A release to the inactive level takes effect at once. The result is a gap between one switch turning off and the other turning on.

The guard interval is a 6-bit count of prescaled ticks. A 2-bit select sets the tick length as 1, 4 or 16 system clocks. One setting serves both channels. Insertion is applied only when the enable is set and the count is nonzero. Otherwise both outputs follow the reference after one register stage. A polarity bit per output sets which electrical level means inactive. The block is meant to sit after a PWM compare stage and in front of a half-bridge driver. Configuration is expected to change only while the block is held in reset.

Top module: `pwm_deadtime_pair`

## Requirements
- R1: When `dt_en_i` is 0 or `dt_val_i` is 0, each channel's active state after a clock edge equals its request sampled at that edge. Channel A's request is `pwm_ref_i` and channel B's request is its inverse. This gives one clock of latency and no extra delay.
- R2: With insertion on, a channel whose request has been continuously true for K sampled edges becomes active after the edge where K exceeds D. D = `dt_val_i` × F, where F is 1 for `ps_sel_i` 2'b00 or 2'b01, 4 for 2'b10 and 16 for 2'b11. Measured from the first edge that sees the request, activation is D clocks later than in R1.
- R3: Channel A and channel B are never active in the same cycle.
- R4: An output equals its polarity bit when the channel is inactive, and the inverse of its polarity bit when the channel is active. Polarity 0 means active high and polarity 1 means active low.
- R5: A channel whose request drops becomes inactive after the very next clock edge, whatever the deadtime setting.
- R6: If a request drops before its deadtime has elapsed, the pending activation is discarded. The output never goes active for that pulse, and a later request restarts the full interval.
- R7: While `rst_i` is high at a clock edge, both channels become inactive and all interval counting is cleared, so both outputs sit at their polarity levels.
- R8: The same interval D applies to channel A on a rising reference edge and to channel B on a falling reference edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pwm_ref_i | input | 1 | Raw PWM reference; high requests channel A, low requests channel B |
| dt_en_i | input | 1 | Deadtime insertion enable |
| ps_sel_i | input | 2 | Tick length select: 00/01 = 1 clock, 10 = 4 clocks, 11 = 16 clocks |
| dt_val_i | input | 6 | Deadtime length in ticks |
| pol_a_i | input | 1 | Channel A polarity: 0 active high, 1 active low |
| pol_b_i | input | 1 | Channel B polarity: 0 active high, 1 active low |
| out_a_o | output | 1 | Channel A gate output |
| out_b_o | output | 1 | Channel B gate output |

## Verification
A tick counter or interval counter holding a stale value shows up as an activation edge that lands the wrong number of clocks after the reference edge. That error is visible on the first pulse after it arises. A pending state that survives a dropped request makes an output go active during a short pulse, within one deadtime. A corrupted activity flag shows up within one clock as a wrong output level or as both channels active together. The bench checks every cycle against a model based on run lengths. It also measures activation delays directly for each prescale setting.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam int unsigned DT_MAX_DIV = 16;

    typedef enum logic [1:0] {
        TICK_X1  = 2'b00,
        TICK_X1B = 2'b01,
        TICK_X4  = 2'b10,
        TICK_X16 = 2'b11
    } tick_sel_e;

    function automatic int unsigned tick_factor(input logic [1:0] sel);
        case (tick_sel_e'(sel))
            TICK_X4:  return 4;
            TICK_X16: return DT_MAX_DIV;
            default:  return 1;
        endcase
    endfunction

endpackage

// File: rtl/dt_mode_decode.sv
module dt_mode_decode #(
    parameter int CNT_W = 6,
    parameter int PSC_W = 4
) (
    input  logic             en_i,
    input  logic [1:0]       sel_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             bypass_o,
    output logic [PSC_W-1:0] tick_last_o
);
    always_comb begin
        bypass_o    = !en_i || (val_i == '0);
        tick_last_o = PSC_W'(dt_pkg::tick_factor(sel_i) - 1);
    end
endmodule

// File: rtl/dt_channel.sv
module dt_channel #(
    parameter int CNT_W = 6,
    parameter int PSC_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             req_i,
    input  logic             bypass_i,
    input  logic [CNT_W-1:0] dt_val_i,
    input  logic [PSC_W-1:0] tick_last_i,
    output logic             act_o
);
    typedef struct packed {
        logic             act;
        logic [PSC_W-1:0] ps;
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!req_i) begin
            st_d.act = 1'b0;
            st_d.ps  = '0;
            st_d.cnt = '0;
        end else if (st_q.act) begin
            st_d.ps  = '0;
            st_d.cnt = '0;
        end else if (bypass_i) begin
            st_d.act = 1'b1;
        end else if (st_q.cnt == dt_val_i) begin
            st_d.act = 1'b1;
            st_d.ps  = '0;
            st_d.cnt = '0;
        end else if (st_q.ps == tick_last_i) begin
            st_d.ps  = '0;
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.ps  = st_q.ps + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign act_o = st_q.act;

    AST_RELEASE_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> !st_q.act); // R5
    AST_BYPASS_FOLLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        bypass_i |=> (st_q.act == $past(req_i))); // R1
    AST_NO_EARLY_ACT: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bypass_i && !st_q.act && (st_q.cnt != dt_val_i)) |=> !st_q.act); // R2
    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (!st_q.act && st_q.cnt == '0 && st_q.ps == '0)); // R7
endmodule

// File: rtl/pwm_deadtime_pair.sv
module pwm_deadtime_pair #(
    parameter int CNT_W = 6,
    parameter int PSC_W = $clog2(dt_pkg::DT_MAX_DIV)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pwm_ref_i,
    input  logic             dt_en_i,
    input  logic [1:0]       ps_sel_i,
    input  logic [CNT_W-1:0] dt_val_i,
    input  logic             pol_a_i,
    input  logic             pol_b_i,
    output logic             out_a_o,
    output logic             out_b_o
);
    localparam int N_CH = 2;

    logic             bypass;
    logic [PSC_W-1:0] tick_last;
    logic [N_CH-1:0]  req, act, pol;

    dt_mode_decode #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_decode (
        .en_i       (dt_en_i),
        .sel_i      (ps_sel_i),
        .val_i      (dt_val_i),
        .bypass_o   (bypass),
        .tick_last_o(tick_last)
    );

    assign req = {~pwm_ref_i, pwm_ref_i};
    assign pol = {pol_b_i, pol_a_i};

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        dt_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chan (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .req_i      (req[i]),
            .bypass_i   (bypass),
            .dt_val_i   (dt_val_i),
            .tick_last_i(tick_last),
            .act_o      (act[i])
        );
    end

    assign out_a_o = act[0] ^ pol[0];
    assign out_b_o = act[1] ^ pol[1];

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !(act[0] && act[1])); // R3
endmodule

// File: tb/pwm_deadtime_pair_test.sv
`timescale 1ns/1ps
module pwm_deadtime_pair_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_r = 1'b0;
    logic       en = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [5:0] val = 6'd0;
    logic       pol_a = 1'b0, pol_b = 1'b0;
    logic       out_a, out_b;
    int checks = 0, failures = 0;
    int run_hi = 0, run_lo = 0;
    bit armed = 0, finished = 0;

    always #2 clk = ~clk;

    pwm_deadtime_pair uut (
        .clk_i(clk), .rst_i(rst), .pwm_ref_i(ref_r), .dt_en_i(en),
        .ps_sel_i(sel), .dt_val_i(val), .pol_a_i(pol_a), .pol_b_i(pol_b),
        .out_a_o(out_a), .out_b_o(out_b)
    );

    function automatic int dlen();
        int f;
        f = (sel == 2'b10) ? 4 : (sel == 2'b11) ? 16 : 1;
        return (en && val != 0) ? int'(val) * f : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            run_hi <= 0; run_lo <= 0;
        end else begin
            run_hi <= ref_r ? ((run_hi < 100000) ? run_hi + 1 : run_hi) : 0;
            run_lo <= !ref_r ? ((run_lo < 100000) ? run_lo + 1 : run_lo) : 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic check_outs(input string tag);
        logic ea, eb;
        if (!armed) return;
        ea = (run_hi >= dlen() + 1);
        eb = (run_lo >= dlen() + 1);
        chk(out_a === (ea ^ pol_a), {tag, " chA"}, int'(out_a), int'(ea ^ pol_a));
        chk(out_b === (eb ^ pol_b), {tag, " chB"}, int'(out_b), int'(eb ^ pol_b));
        chk(!((out_a ^ pol_a) && (out_b ^ pol_b)), "R3 overlap", 1, 0);
    endtask

    task automatic step(input logic r, input string tag);
        @(negedge clk);
        check_outs(tag);
        ref_r = r;
    endtask

    task automatic configure(input logic e, input logic [1:0] s, input logic [5:0] v,
                             input logic pa, input logic pb);
        @(negedge clk);
        check_outs("R7");
        rst = 1'b1; en = e; sel = s; val = v; pol_a = pa; pol_b = pb; ref_r = 1'b0;
        repeat (2) step(1'b0, "R7");
        @(negedge clk);
        check_outs("R7");
        rst = 1'b0;
    endtask

    task automatic measure(input bit chan_b, input string tag);
        int k;
        int lim;
        lim = dlen() + 40;
        repeat (dlen() + 3) step(chan_b ? 1'b1 : 1'b0, tag);
        step(chan_b ? 1'b0 : 1'b1, tag);
        k = 0;
        for (int i = 1; i <= lim; i++) begin
            step(chan_b ? 1'b0 : 1'b1, tag);
            if ((chan_b ? (out_b ^ pol_b) : (out_a ^ pol_a)) && k == 0) k = i;
        end
        chk(k == dlen() + 1, tag, k, dlen() + 1);
    endtask

    task automatic random_run(input int n, input string tag);
        int len;
        logic r;
        r = 1'b0;
        for (int i = 0; i < n; i++) begin
            r = ~r;
            len = $urandom_range(1, 2 * dlen() + 3);
            repeat (len) step(r, tag);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        armed = 1;
        // R7: reset levels with both polarities
        chk(out_a === 1'b0 && out_b === 1'b0, "R7 reset pol=00", int'({out_a, out_b}), 0);
        configure(1'b1, 2'b11, 6'd5, 1'b1, 1'b1);
        chk(out_a === 1'b1 && out_b === 1'b1, "R7 reset pol=11", int'({out_a, out_b}), 3);
        // R1: bypass, enable off and zero count
        configure(1'b0, 2'b11, 6'd9, 1'b0, 1'b0);
        random_run(40, "R1");
        measure(0, "R1");
        configure(1'b1, 2'b10, 6'd0, 1'b0, 1'b0);
        random_run(40, "R1");
        measure(1, "R1");
        // R2 / R8: delay per prescale select
        configure(1'b1, 2'b00, 6'd3, 1'b0, 1'b0);
        measure(0, "R2"); measure(1, "R8");
        configure(1'b1, 2'b01, 6'd5, 1'b0, 1'b0);
        measure(0, "R2"); measure(1, "R8");
        configure(1'b1, 2'b10, 6'd2, 1'b0, 1'b0);
        measure(0, "R2"); measure(1, "R8");
        configure(1'b1, 2'b11, 6'd1, 1'b0, 1'b0);
        measure(0, "R2"); measure(1, "R8");
        configure(1'b1, 2'b00, 6'd63, 1'b0, 1'b0);
        measure(0, "R2");
        // R6: short pulse cancelled, then full interval again
        configure(1'b1, 2'b00, 6'd10, 1'b0, 1'b0);
        begin
            bit seen;
            seen = 0;
            repeat (15) step(1'b0, "R6");
            repeat (5) begin step(1'b1, "R6"); if (out_a) seen = 1; end
            repeat (15) begin step(1'b0, "R6"); if (out_a) seen = 1; end
            chk(!seen, "R6 cancelled pulse", int'(seen), 0);
        end
        measure(0, "R6");
        // R4 / R5: polarity variants with random pulses
        configure(1'b1, 2'b10, 6'd3, 1'b1, 1'b1);
        random_run(30, "R4");
        configure(1'b1, 2'b00, 6'd4, 1'b0, 1'b1);
        random_run(30, "R4");
        configure(1'b0, 2'b00, 6'd4, 1'b1, 1'b0);
        random_run(30, "R5");
        // mixed random configurations
        for (int b = 0; b < 8; b++) begin
            logic [5:0] rv;
            rv = 6'($urandom_range(0, 12));
            configure(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), rv,
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            random_run(20, "R5");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule